// File: doc/BRIEF.md
# Cascaded Reset Generator

This block turns a handful of reset sources into a row of reset outputs whose reach narrows step by step. Output level 0 is the widest reset; each level below it is asserted whenever the level above is, and can also be asserted by sources of its own. The sources are the power-on reset, an external reset pin, a watchdog expiry and a per-level software request. The pin and watchdog inputs arrive asynchronously and pass through two-flop synchronisers. The oscillator-ready and flash-ready indications pass through the same synchronisers.

Every level counts a fixed number of cycles after its last cause goes away before it releases. The widest level also waits after a power-on or pin reset until both readiness indications have been seen. As a result, the levels come out of reset one after another, from the widest to the narrowest. A software write can pulse any chosen level. A small status field reports which source caused the latest reset.

Top module: `rstc_cascade`

## Requirements
- R1: While `por_i` is high, every bit of `rst_o` is 1 and `cause_o` is 0 (power-on). All internal state returns to its initial value.
- R2: `ext_rst_i` and `wdt_rst_i` are synchronised through two flops. A rise of the pin input appears on `rst_o[0]` at the third rising clock edge after it is applied.
- R3: Whenever `rst_o[i-1]` is 1, `rst_o[i]` is also 1.
- R4: A level stays asserted for exactly HOLD cycles after its last active cause. Timed from the edge at which the pin input is first sampled low, level i falls at edge (i+1)*HOLD+4.
- R5: After power-on or pin reset, level 0 holds until `osc_ok_i` and `flash_ok_i` are both seen high through the synchronisers.
- R6: Per-level source masks select which sources a level responds to. By default the pin drives level 0 and the watchdog drives level 1, so a watchdog reset leaves `rst_o[0]` at 0.
- R7: A write with `sw_wr_i`=1 and bit i of `sw_lvl_i` set asserts level i from the next edge on. The request stays active for PULSE cycles and is then stretched by HOLD cycles. Levels above i are not affected.
- R8: A software request for level i is discarded while level i-1 is asserted. A pending request is cleared when level i-1 asserts.
- R9: `cause_o` encodes 0 = power-on, 1 = pin, 2 = watchdog, 3 = software. When sources coincide, pin takes priority over watchdog, and watchdog over software. The value holds until a newer cause arrives or power-on occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow free-running clock |
| por_i | input | 1 | Power-on reset, active high, synchronous |
| ext_rst_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_rst_i | input | 1 | Watchdog expiry, active high, asynchronous |
| osc_ok_i | input | 1 | Oscillator stable indication |
| flash_ok_i | input | 1 | Flash ready indication |
| sw_wr_i | input | 1 | Software request strobe |
| sw_lvl_i | input | NLVL | One bit per level to pulse |
| rst_o | output | NLVL | Reset outputs, bit 0 widest, active high |
| cause_o | output | 2 | Cause of the latest reset |

## Verification
The hardest situation to reach from the ports is a software request that arrives while the level above is already in reset. It is only discarded if it lands inside the window in which the upper level is active.

The stimulus first fires a watchdog pulse. It waits the synchroniser latency until level 1 is seen asserted, and only then writes the level-2 request. It then shows that the release timing of level 2 matches a pure watchdog reset, and that the cause field still reads watchdog rather than software.

Coincident pin and watchdog edges are driven in the same cycle to expose the priority order in the cause field.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NSRC    = 2;
  localparam int SRC_PIN = 0;
  localparam int SRC_WDT = 1;

  typedef enum logic [1:0] {
    CAUSE_POR = 2'd0,
    CAUSE_PIN = 2'd1,
    CAUSE_WDT = 2'd2,
    CAUSE_SW  = 2'd3
  } cause_e;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rstc_level.sv
module rstc_level #(
  parameter int                      HOLD  = 16,
  parameter int                      PULSE = 4,
  parameter int                      NSRC  = 2,
  parameter logic [NSRC-1:0]         MASK  = '0,
  parameter bit                      TOP   = 1'b0
) (
  input  logic            clk,
  input  logic            por,
  input  logic [NSRC-1:0] src,
  input  logic            upper_on,
  input  logic            sw_set,
  output logic            on_o,
  output logic            rst_o,
  output logic            sw_busy_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam int PW = $clog2(PULSE + 1);

  logic [CW-1:0] hold_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          sw_q;
  logic          act;
  logic          sw_clr;

  assign act       = (|(src & MASK)) | upper_on | sw_q;
  assign on_o      = act | (hold_cnt != '0);
  assign sw_clr    = TOP ? 1'b0 : upper_on;
  assign sw_busy_o = sw_q;

  always_ff @(posedge clk) begin
    if (por) begin
      hold_cnt <= CW'(HOLD);
      rst_o    <= 1'b1;
    end else begin
      rst_o <= on_o;
      if (act)
        hold_cnt <= CW'(HOLD);
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      sw_q      <= 1'b0;
      pulse_cnt <= '0;
    end else if (sw_clr) begin
      sw_q      <= 1'b0;
      pulse_cnt <= '0;
    end else if (sw_q) begin
      if (pulse_cnt == PW'(PULSE - 1)) begin
        sw_q      <= 1'b0;
        pulse_cnt <= '0;
      end else begin
        pulse_cnt <= pulse_cnt + 1'b1;
      end
    end else if (sw_set) begin
      sw_q      <= 1'b1;
      pulse_cnt <= '0;
    end
  end
endmodule

// File: rtl/rstc_cascade.sv
module rstc_cascade
  import rstc_pkg::*;
#(
  parameter int                       NLVL      = 4,
  parameter int                       HOLD      = 16,
  parameter int                       PULSE     = 4,
  parameter logic [NLVL*NSRC-1:0]     SRC_MASKS = 8'b00_00_10_01
) (
  input  logic            clk,
  input  logic            por_i,
  input  logic            ext_rst_i,
  input  logic            wdt_rst_i,
  input  logic            osc_ok_i,
  input  logic            flash_ok_i,
  input  logic            sw_wr_i,
  input  logic [NLVL-1:0] sw_lvl_i,
  output logic [NLVL-1:0] rst_o,
  output logic [1:0]      cause_o
);
  localparam int NSYNC = NSRC + 2;

  logic [NSYNC-1:0] sync_q;
  logic [NSRC-1:0]  src_s;
  logic             osc_s, flash_s;
  logic             wait_q;
  logic [NLVL-1:0]  lvl_on, sw_busy;
  cause_e           cause_q;

  rstc_sync #(.W(NSYNC)) u_sync (
    .clk (clk),
    .clr (por_i),
    .d   ({flash_ok_i, osc_ok_i, wdt_rst_i, ext_rst_i}),
    .q   (sync_q)
  );

  assign src_s[SRC_PIN] = sync_q[0];
  assign src_s[SRC_WDT] = sync_q[1];
  assign osc_s          = sync_q[2];
  assign flash_s        = sync_q[3];

  // widest level waits for both readiness flags after power-on or pin reset
  always_ff @(posedge clk) begin
    if (por_i)
      wait_q <= 1'b1;
    else if (src_s[SRC_PIN])
      wait_q <= 1'b1;
    else if (osc_s && flash_s)
      wait_q <= 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_lvl
      logic upper;
      if (g == 0) begin : g_top
        assign upper = wait_q;
      end else begin : g_low
        assign upper = lvl_on[g-1];
      end
      rstc_level #(
        .HOLD  (HOLD),
        .PULSE (PULSE),
        .NSRC  (NSRC),
        .MASK  (SRC_MASKS[g*NSRC +: NSRC]),
        .TOP   (g == 0)
      ) u_lvl (
        .clk       (clk),
        .por       (por_i),
        .src       (src_s),
        .upper_on  (upper),
        .sw_set    (sw_wr_i & sw_lvl_i[g]),
        .on_o      (lvl_on[g]),
        .rst_o     (rst_o[g]),
        .sw_busy_o (sw_busy[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (por_i)
      cause_q <= CAUSE_POR;
    else if (src_s[SRC_PIN])
      cause_q <= CAUSE_PIN;
    else if (src_s[SRC_WDT])
      cause_q <= CAUSE_WDT;
    else if (|sw_busy)
      cause_q <= CAUSE_SW;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rstc_cascade_chk.sv
module rstc_cascade_chk #(
  parameter int NLVL = 4,
  parameter int HOLD = 16
) (
  input logic            clk,
  input logic            por_i,
  input logic            ext_rst_i,
  input logic [NLVL-1:0] rst_o,
  input logic [1:0]      cause_o
);
  localparam int HW = $clog2(HOLD + 2);

  logic [HW-1:0] hi_cnt [NLVL];

  // R1: leaving power-on finds every level asserted and cause cleared
  a_r1_por_state: assert property (@(posedge clk) disable iff (por_i)
    $fell(por_i) |-> ((&rst_o) && (cause_o == 2'd0)));

  // R2: level 0 cannot drop unless the pin was low through the synchroniser
  a_r2_pin_sync: assert property (@(posedge clk) disable iff (por_i)
    $fell(rst_o[0]) |-> !$past(ext_rst_i, 2));

  // R9: the cause only changes together with an asserted reset
  a_r9_cause_with_reset: assert property (@(posedge clk) disable iff (por_i)
    !$stable(cause_o) |-> (|rst_o));

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_chk
      always_ff @(posedge clk) begin
        if (por_i)
          hi_cnt[g] <= '0;
        else if (!rst_o[g])
          hi_cnt[g] <= '0;
        else if (hi_cnt[g] != HW'(HOLD + 1))
          hi_cnt[g] <= hi_cnt[g] + 1'b1;
      end

      // R4: no level releases before its stretch has run
      a_r4_min_hold: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_o[g]) |-> (hi_cnt[g] >= HW'(HOLD)));

      if (g > 0) begin : g_casc
        // R3: a wider level implies the narrower one
        a_r3_cascade: assert property (@(posedge clk) disable iff (por_i)
          rst_o[g-1] |-> rst_o[g]);
      end
    end
  endgenerate
endmodule

bind rstc_cascade rstc_cascade_chk #(.NLVL(NLVL), .HOLD(HOLD)) u_chk (
  .clk       (clk),
  .por_i     (por_i),
  .ext_rst_i (ext_rst_i),
  .rst_o     (rst_o),
  .cause_o   (cause_o)
);

// File: tb/sim_rstc_cascade.sv
`timescale 1ns/1ps
module sim_rstc_cascade;
  localparam int NLVL  = 4;
  localparam int HOLD  = 16;
  localparam int PULSE = 4;

  logic            clk = 1'b0;
  logic            por_i = 1'b1;
  logic            ext_rst_i = 1'b0, wdt_rst_i = 1'b0;
  logic            osc_ok_i = 1'b0, flash_ok_i = 1'b0;
  logic            sw_wr_i = 1'b0;
  logic [NLVL-1:0] sw_lvl_i = '0;
  logic [NLVL-1:0] rst_o;
  logic [1:0]      cause_o;

  int tests = 0, fails = 0, cyc = 0;
  int rel [NLVL];
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  rstc_cascade #(.NLVL(NLVL), .HOLD(HOLD), .PULSE(PULSE),
                 .SRC_MASKS(8'b00_00_10_01)) u0 (
    .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .wdt_rst_i(wdt_rst_i),
    .osc_ok_i(osc_ok_i), .flash_ok_i(flash_ok_i), .sw_wr_i(sw_wr_i),
    .sw_lvl_i(sw_lvl_i), .rst_o(rst_o), .cause_o(cause_o));

  // ---------------- behavioural reference model ----------------
  bit m_in1[4], m_in2[4];          // two-stage delay per async input
  bit m_wait;
  int m_left[NLVL], m_swn[NLVL];
  bit m_sw[NLVL];
  bit [NLVL-1:0] m_rst;
  int m_cause;

  function automatic bit pin_hits(int l); return l == 0; endfunction
  function automatic bit wdt_hits(int l); return l == 1; endfunction

  always @(posedge clk) begin
    bit on_v [NLVL];
    bit act_v[NLVL];
    bit any_sw;
    started = 1'b1;
    if (por_i) begin
      for (int k = 0; k < 4; k++) begin m_in1[k] = 0; m_in2[k] = 0; end
      m_wait = 1; m_rst = '1; m_cause = 0;
      for (int l = 0; l < NLVL; l++) begin m_left[l] = HOLD; m_sw[l] = 0; m_swn[l] = 0; end
    end else begin
      any_sw = 0;
      for (int l = 0; l < NLVL; l++) begin
        act_v[l] = (l == 0 ? m_wait : on_v[l-1]) || m_sw[l] ||
                   (pin_hits(l) && m_in2[0]) || (wdt_hits(l) && m_in2[1]);
        on_v[l]  = act_v[l] || (m_left[l] > 0);
        any_sw   = any_sw || m_sw[l];
      end
      if (m_in2[0]) m_cause = 1;
      else if (m_in2[1]) m_cause = 2;
      else if (any_sw) m_cause = 3;
      for (int l = 0; l < NLVL; l++) begin
        m_rst[l]  = on_v[l];
        m_left[l] = act_v[l] ? HOLD : (m_left[l] > 0 ? m_left[l] - 1 : 0);
        if (l > 0 && on_v[l-1]) begin m_sw[l] = 0; m_swn[l] = 0; end
        else if (m_sw[l]) begin
          if (m_swn[l] == PULSE - 1) begin m_sw[l] = 0; m_swn[l] = 0; end
          else m_swn[l]++;
        end else if (sw_wr_i && sw_lvl_i[l]) begin m_sw[l] = 1; m_swn[l] = 0; end
      end
      if (m_in2[0]) m_wait = 1;
      else if (m_in2[2] && m_in2[3]) m_wait = 0;
      for (int k = 0; k < 4; k++) m_in2[k] = m_in1[k];
      m_in1[0] = ext_rst_i; m_in1[1] = wdt_rst_i;
      m_in1[2] = osc_ok_i;  m_in1[3] = flash_ok_i;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      tests++;
      if (rst_o !== m_rst) begin
        fails++;
        $display("FAIL R4 cycle %0d rst_o actual %b expected %b", cyc, rst_o, m_rst);
      end
      tests++;
      if (cause_o !== 2'(m_cause)) begin
        fails++;
        $display("FAIL R9 cycle %0d cause_o actual %0d expected %0d", cyc, cause_o, m_cause);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic edges(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // count rising edges until each level reads 0
  task automatic wait_release();
    for (int l = 0; l < NLVL; l++) rel[l] = 0;
    for (int e = 1; e < 400; e++) begin
      bit done;
      @(negedge clk);
      done = 1;
      for (int l = 0; l < NLVL; l++) begin
        if (rel[l] == 0 && rst_o[l] == 1'b0) rel[l] = e;
        if (rel[l] == 0) done = 0;
      end
      if (done) break;
    end
  endtask

  task automatic wdt_pulse();
    wdt_rst_i = 1; edges(1); wdt_rst_i = 0; edges(2);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    edges(3);
    chk("R1 reset rst_o", int'(rst_o), 15);
    chk("R1 reset cause", int'(cause_o), 0);
    por_i = 0;
    edges(40);
    chk("R5 held without ready flags", int'(rst_o[0]), 1);
    osc_ok_i = 1;
    edges(30);
    chk("R5 held with oscillator only", int'(rst_o[0]), 1);
    flash_ok_i = 1;
    wait_release();
    for (int l = 0; l < NLVL; l++)
      chk($sformatf("R5 release after ready, level %0d", l), rel[l], (l + 1) * HOLD + 4);

    // pin reset
    ext_rst_i = 1;
    begin
      int n = 0;
      for (int e = 1; e < 10; e++) begin
        @(negedge clk);
        if (rst_o[0]) begin n = e; break; end
      end
      chk("R2 pin latency edges", n, 3);
    end
    chk("R3 all levels follow level 0", int'(rst_o), 15);
    chk("R9 cause pin", int'(cause_o), 1);
    edges(4);
    ext_rst_i = 0;
    wait_release();
    for (int l = 0; l < NLVL; l++)
      chk($sformatf("R4 staggered release level %0d", l), rel[l], (l + 1) * HOLD + 4);

    // watchdog
    wdt_pulse();
    chk("R6 watchdog spares level 0", int'(rst_o), 4'b1110);
    chk("R9 cause watchdog", int'(cause_o), 2);
    wait_release();
    chk("R4 watchdog level 1 release", rel[1], HOLD + 1);
    chk("R6 level 0 stayed low", rel[0], 1);

    // software pulse on level 2
    sw_lvl_i = 4'b0100; sw_wr_i = 1; edges(1); sw_wr_i = 0; sw_lvl_i = '0;
    edges(1);
    chk("R7 software level 2 only downward", int'(rst_o), 4'b1100);
    chk("R9 cause software", int'(cause_o), 3);
    wait_release();
    chk("R7 level 2 length", rel[2], PULSE + HOLD);
    chk("R7 level 3 length", rel[3], PULSE + 2 * HOLD);

    // software request while level above is active
    wdt_pulse();
    sw_lvl_i = 4'b0100; sw_wr_i = 1; edges(1); sw_wr_i = 0; sw_lvl_i = '0;
    wait_release();
    chk("R8 ignored request, level 2 release", rel[2], 2 * HOLD);
    chk("R8 cause still watchdog", int'(cause_o), 2);

    // coincident pin and watchdog
    ext_rst_i = 1; wdt_rst_i = 1; edges(1); wdt_rst_i = 0; edges(2);
    chk("R9 pin beats watchdog", int'(cause_o), 1);
    ext_rst_i = 0;
    wait_release();
    edges(10);
    chk("R9 cause persists", int'(cause_o), 1);

    // power-on again
    por_i = 1; edges(2);
    chk("R1 second power-on rst_o", int'(rst_o), 15);
    chk("R1 second power-on cause", int'(cause_o), 0);
    por_i = 0;
    wait_release();
    chk("R5 ready flags already high", rel[0], HOLD + 4);
    edges(5);
    summary();
  end
endmodule